// File: doc/BRIEF.md
# Serial Memory Slave Command Front End

This block is the serial-facing command controller of a memory that sits as a slave on an SPI bus in mode 0. The clock, chip-select and data-in pins are oversampled by the system clock through a short synchronizer. The block shifts in an opcode, MSB first, while chip select is low. It recognises four instructions: write enable (0x06), write (0x02), status read (0x05) and status write (0x01). It holds the write-enable latch and a small status register.

A write instruction takes a 16-bit address and one or more data bytes. The data bytes go into a page-sized staging RAM. When chip select rises on a byte boundary, the block issues one launch pulse to a back-end array writer. The pulse carries the start address and a byte count. The back end fetches the staged bytes through a read port and reports its progress on a busy input.

Several rules guard the array. A write lands only after a separate enable frame. A write into the protected range is refused. While the back end is busy, every command except a status read is ignored. A frame that ends part-way through a byte is dropped.

Top module: `spi_mem_cmd_ctrl`

## Requirements
- R1: The write-enable latch is set only by a frame that holds exactly one complete 0x06 opcode byte and then ends with chip select rising. A 0x06 followed by more bytes in the same frame sets nothing. Write (0x02) and status-write (0x01) frames have no effect while the latch is clear.
- R2: The write opcode 0x02 is followed by a 16-bit address, high byte first, and then data bytes. Every byte is MSB first and is sampled on the SCK rising edge. The staged data are delivered to the back end at offset (address + n) mod 64.
- R3: Only the low 13 address bits are used, so the top three bits of the 16-bit address field never reach `wr_addr`.
- R4: `wr_start` pulses only after chip select has risen, never while the frame is still open.
- R5: While a write is in progress (status bit 0 set), every opcode other than 0x05 is ignored for the rest of its frame.
- R6: Status read (0x05) shifts the status byte out on `so`, MSB first. Each bit changes on an SCK falling edge. The live status is reloaded for every further byte in the frame. Bit 0 means write in progress; it is the pending-launch flag or'd with `busy`. Bit 1 is the write-enable latch. Bits 6..4 read 0.
- R7: Status write (0x01) changes only bit 7 and bits 3..2 and clears the write-enable latch. All other bits keep their values.
- R8: Bits 3..2 select the protected range: 00 none, 01 the top quarter (address bits 12..11 = 11), 10 the top half (bit 12 = 1), 11 everything. A write whose start address falls in that range launches nothing.
- R9: When `busy` falls at the end of a launched write, the write-enable latch clears.
- R10: The low 6 address bits advance after each data byte and wrap within the 64-byte page, so later bytes overwrite earlier ones. `wr_count` saturates at 64.
- R11: If chip select rises while a byte is incomplete, the frame is aborted: no launch and no change to the latch.
- R12: `so_en` is high only during the data phase of a status-read frame. It drops when chip select rises, and `so` is then held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (valid when so_en) |
| so_en | output | 1 | Output-enable for the SO pad; low means high impedance |
| wr_start | output | 1 | One-cycle launch pulse to the array writer |
| wr_addr | output | 13 | Start address of the launched write |
| wr_count | output | 7 | Number of staged bytes (1..64) |
| busy | input | 1 | Array writer is programming |
| buf_raddr | input | 6 | Staging RAM read address from the writer |
| buf_rdata | output | 8 | Staging RAM data, one cycle after buf_raddr |

## Verification
Every result goes through the input synchronizer, an edge-detect register and an output register, so the sampling points follow that latency. `so` changes about four system clocks after an SCK falling edge. The bench samples it seven clocks later, just before the next rising edge it drives. `wr_start` appears about four clocks after chip select rises. The bench checks the launch count before raising chip select and again sixteen clocks after. The staging RAM answers one clock after `buf_raddr` changes, so the bench's array model reads each byte on the following clock. Status values are read back over the serial port only after `busy` has been low for several clocks, so the write-in-progress and latch bits have settled.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE, S_OPC, S_AH, S_AL, S_DAT, S_WEN, S_SRD, S_RD, S_SKIP
  } cmd_state_t;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_mem_frame.sv
module spi_mem_frame (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_s,
  input  logic       sck_s,
  input  logic       si_s,
  output logic       cs_start,
  output logic       cs_end,
  output logic       end_aligned,
  output logic       sck_fall,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  logic       cs_d, sck_d;
  logic [6:0] shreg;
  logic [2:0] bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d        <= 1'b1;
      sck_d       <= 1'b0;
      shreg       <= '0;
      bit_cnt     <= '0;
      cs_start    <= 1'b0;
      cs_end      <= 1'b0;
      end_aligned <= 1'b0;
      sck_fall    <= 1'b0;
      byte_vld    <= 1'b0;
      byte_q      <= '0;
    end else begin
      cs_d        <= cs_n_s;
      sck_d       <= sck_s;
      cs_start    <= cs_d && !cs_n_s;
      cs_end      <= !cs_d && cs_n_s;
      end_aligned <= (bit_cnt == 3'd0);
      sck_fall    <= !cs_n_s && sck_d && !sck_s;
      byte_vld    <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
      end else if (!sck_d && sck_s) begin
        shreg   <= {shreg[5:0], si_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {shreg, si_s};
        end
      end
    end
  end
endmodule

// File: rtl/spi_mem_page_buf.sv
module spi_mem_page_buf #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_mem_status.sv
module spi_mem_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       wel_set,
  input  logic       sr_write,
  input  logic       sr_lock,
  input  logic [1:0] sr_bp,
  input  logic       launch,
  input  logic       busy,
  input  logic [1:0] quarter,
  output logic [7:0] status,
  output logic       wel,
  output logic       wip,
  output logic       prot
);
  logic       lock_q, wel_q, wip_q, busy_d;
  logic [1:0] bp_q;
  logic       done;

  assign done = wip_q && busy_d && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      bp_q   <= 2'b00;
      wel_q  <= 1'b0;
      wip_q  <= 1'b0;
      busy_d <= 1'b0;
    end else begin
      busy_d <= busy;
      if (launch) wip_q <= 1'b1;
      else if (done) wip_q <= 1'b0;
      if (done || sr_write) wel_q <= 1'b0;
      else if (wel_set) wel_q <= 1'b1;
      if (sr_write) begin
        lock_q <= sr_lock;
        bp_q   <= sr_bp;
      end
    end
  end

  always_comb begin
    case (bp_q)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (quarter == 2'b11);
      2'b10:   prot = quarter[1];
      default: prot = 1'b1;
    endcase
  end

  assign wel    = wel_q;
  assign wip    = wip_q | busy;
  assign status = {lock_q, 3'b000, bp_q, wel_q, wip};

  // R9
  wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !wel_q);
  // R7
  sr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sr_write |=> ($stable(bp_q) && $stable(lock_q)));
endmodule

// File: rtl/spi_mem_cmd_ctrl.sv
module spi_mem_cmd_ctrl
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_en,
  output logic              wr_start,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PAGE_W:0]   wr_count,
  input  logic              busy,
  input  logic [PAGE_W-1:0] buf_raddr,
  output logic [7:0]        buf_rdata
);
  localparam int CNT_W = PAGE_W + 1;
  localparam logic [CNT_W-1:0] PAGE_BYTES = CNT_W'(1 << PAGE_W);

  logic [2:0] pins_s;
  logic       cs_start, cs_end, end_aligned, sck_fall, byte_vld;
  logic [7:0] byte_q;

  spi_mem_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, si}), .q(pins_s)
  );

  spi_mem_frame u_frame (
    .clk(clk), .rst(rst),
    .cs_n_s(pins_s[2]), .sck_s(pins_s[1]), .si_s(pins_s[0]),
    .cs_start(cs_start), .cs_end(cs_end), .end_aligned(end_aligned),
    .sck_fall(sck_fall), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  cmd_state_t        st;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] wr_ptr;
  logic [CNT_W-1:0]  data_cnt;
  logic [7:0]        sr_byte, out_sh;
  logic              sr_got;
  logic [2:0]        out_cnt;
  logic [7:0]        status;
  logic              wel, wip, prot;
  logic              wr_go, wel_go, sr_go, buf_we;

  assign wr_go  = cs_end && end_aligned && (st == S_DAT) && (data_cnt != '0) && wel && !prot;
  assign wel_go = cs_end && end_aligned && (st == S_WEN);
  assign sr_go  = cs_end && end_aligned && (st == S_SRD) && sr_got && wel;
  assign buf_we = byte_vld && (st == S_DAT);

  spi_mem_status u_status (
    .clk(clk), .rst(rst),
    .wel_set(wel_go), .sr_write(sr_go),
    .sr_lock(sr_byte[7]), .sr_bp(sr_byte[3:2]),
    .launch(wr_go), .busy(busy),
    .quarter(addr_q[ADDR_W-1 -: 2]),
    .status(status), .wel(wel), .wip(wip), .prot(prot)
  );

  spi_mem_page_buf #(.AW(PAGE_W), .DW(8)) u_buf (
    .clk(clk), .we(buf_we), .waddr(wr_ptr), .wdata(byte_q),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      addr_q   <= '0;
      wr_ptr   <= '0;
      data_cnt <= '0;
      sr_byte  <= '0;
      sr_got   <= 1'b0;
      out_sh   <= '0;
      out_cnt  <= '0;
      so       <= 1'b0;
      so_en    <= 1'b0;
      wr_start <= 1'b0;
      wr_addr  <= '0;
      wr_count <= '0;
    end else begin
      wr_start <= wr_go;
      if (wr_go) begin
        wr_addr  <= addr_q;
        wr_count <= data_cnt;
      end

      if (cs_start) begin
        st       <= S_OPC;
        sr_got   <= 1'b0;
        data_cnt <= '0;
      end else if (cs_end) begin
        st    <= S_IDLE;
        so    <= 1'b0;
        so_en <= 1'b0;
      end else if (byte_vld) begin
        case (st)
          S_OPC: begin
            if (wip && byte_q != OP_RDSR) st <= S_SKIP;
            else begin
              case (byte_q)
                OP_WREN:  st <= S_WEN;
                OP_WRITE: st <= S_AH;
                OP_WRSR:  st <= S_SRD;
                OP_RDSR: begin
                  st      <= S_RD;
                  out_sh  <= status;
                  out_cnt <= '0;
                end
                default:  st <= S_SKIP;
              endcase
            end
          end
          S_AH: begin
            addr_q[ADDR_W-1:8] <= byte_q[ADDR_W-9:0];
            st <= S_AL;
          end
          S_AL: begin
            addr_q[7:0] <= byte_q;
            wr_ptr      <= byte_q[PAGE_W-1:0];
            st          <= S_DAT;
          end
          S_DAT: begin
            wr_ptr <= wr_ptr + 1'b1;
            if (data_cnt != PAGE_BYTES) data_cnt <= data_cnt + 1'b1;
          end
          S_WEN: st <= S_SKIP;
          S_SRD: begin
            if (!sr_got) begin
              sr_byte <= byte_q;
              sr_got  <= 1'b1;
            end
          end
          default: ;
        endcase
      end else if (sck_fall && st == S_RD) begin
        so      <= out_sh[7];
        so_en   <= 1'b1;
        out_cnt <= out_cnt + 3'd1;
        out_sh  <= (out_cnt == 3'd7) ? status : {out_sh[6:0], 1'b0};
      end
    end
  end

  // R4
  launch_after_cs_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> $past(cs_end));
  // R5
  launch_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> !$past(wip));
  // R8
  launch_unprot_chk: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> !$past(prot));
  // R12
  so_read_only_chk: assert property (@(posedge clk) disable iff (rst)
    so_en |-> (st == S_RD));
endmodule

// File: tb/spi_mem_cmd_ctrl_test.sv
module spi_mem_cmd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic       so, so_en, wr_start, busy = 1'b0;
  logic [12:0] wr_addr;
  logic [6:0]  wr_count;
  logic [5:0]  buf_raddr = '0;
  logic [7:0]  buf_rdata;

  int n_chk = 0, n_fail = 0, launches = 0, bad_oe = 0;
  logic in_read = 1'b0, finished = 1'b0;
  logic [12:0] cap_addr;
  int          cap_cnt;
  logic [7:0]  cap [64];
  localparam int BUSY_HOLD = 1500;

  always #2 clk = ~clk;

  spi_mem_cmd_ctrl uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_en(so_en), .wr_start(wr_start), .wr_addr(wr_addr),
    .wr_count(wr_count), .busy(busy), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata)
  );

  always @(negedge clk) if (so_en && !in_read) bad_oe++;

  // array writer model
  initial begin
    forever begin
      @(negedge clk);
      if (wr_start) begin
        launches++;
        cap_addr = wr_addr;
        cap_cnt  = int'(wr_count);
        busy = 1'b1;
        for (int k = 0; k < cap_cnt; k++) begin
          buf_raddr = wr_addr[5:0] + 6'(k);
          @(negedge clk);
          @(negedge clk);
          cap[buf_raddr] = buf_rdata;
        end
        repeat (BUSY_HOLD) @(negedge clk);
        busy = 1'b0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk) si = tx[i];
      repeat (7) @(negedge clk);
      rx[i] = so;
      sck = 1'b1;
      repeat (8) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_high();
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic send1(input logic [7:0] b);
    logic [7:0] r;
    xfer(b, 8, r);
  endtask

  task automatic wren();
    cs_low(); send1(8'h06); cs_high();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_low(); send1(8'h01); send1(v); cs_high();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    in_read = 1'b1;
    cs_low(); send1(8'h05); xfer(8'h00, 8, s); cs_high();
    in_read = 1'b0;
    r = s;
  endtask

  task automatic wframe(input logic [15:0] a, input int n, input int seed);
    cs_low(); send1(8'h02); send1(a[15:8]); send1(a[7:0]);
    for (int i = 0; i < n; i++) send1(8'((seed + 3 * i) & 255));
    cs_high();
  endtask

  task automatic wait_idle();
    repeat (6) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (199000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, s2, r;
    logic [7:0] expb [64];
    int base, mism;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // reset state
    chk("R12 reset so_en", int'(so_en), 0);
    rdsr(s);
    chk("R6 reset status", int'(s), 8'h00);

    // R1: write in the enable frame is discarded, latch stays clear
    cs_low(); send1(8'h06); send1(8'h02); send1(8'h00); send1(8'h10); send1(8'hAA); cs_high();
    wait_idle();
    chk("R1 no launch in enable frame", launches, 0);
    rdsr(s);
    chk("R1 latch clear after mixed frame", int'(s), 8'h00);
    wframe(16'h0010, 1, 8'h33);
    wait_idle();
    chk("R1 write refused without latch", launches, 0);

    // R1/R2/R3/R4: byte write with top address bits set
    wren();
    rdsr(s);
    chk("R1 latch set", int'(s), 8'h02);
    cs_low(); send1(8'h02); send1(8'hE0); send1(8'h05); send1(8'h5A);
    repeat (20) @(negedge clk);
    chk("R4 no launch while cs low", launches, 0);
    cs_high();
    chk("R4 launch after cs high", launches, 1);
    chk("R3 address masked", int'(wr_addr), 13'h0005);
    // R6 busy visible
    rdsr(s);
    chk("R6 wip and latch during write", int'(s), 8'h03);
    // R5 commands ignored while busy
    wren();
    wframe(16'h0040, 1, 8'h11);
    wait_idle();
    chk("R5 write ignored while busy", launches, 1);
    chk("R2 byte delivered", int'(cap[5]), 8'h5A);
    chk("R2 count one", cap_cnt, 1);
    rdsr(s);
    chk("R9 latch cleared, R5 enable ignored", int'(s), 8'h00);

    // R7 status write
    wren();
    wrsr(8'hFF);
    rdsr(s);
    chk("R7 writable bits only", int'(s), 8'h8C);
    wrsr(8'h00);
    rdsr(s);
    chk("R7 refused without latch", int'(s), 8'h8C);
    in_read = 1'b1;
    cs_low(); send1(8'h05); xfer(8'h00, 8, s); xfer(8'h00, 8, s2); cs_high();
    in_read = 1'b0;
    chk("R6 repeated status byte", int'(s2), int'(s));

    // R8 protection sweep
    for (int bp = 0; bp < 4; bp++) begin
      wren();
      wrsr(8'(bp << 2));
      rdsr(s);
      chk("R8 bp readback", int'(s[3:2]), bp);
      for (int q = 0; q < 4; q++) begin
        logic exp_prot;
        base = launches;
        exp_prot = (bp == 3) || (bp == 2 && q >= 2) || (bp == 1 && q == 3);
        wren();
        wframe(16'((q << 11) + 64 + q), 1, q);
        wait_idle();
        chk("R8 protection decision", launches - base, exp_prot ? 0 : 1);
      end
    end
    wren();
    wrsr(8'h00);

    // R10 page write with rollover
    wren();
    wframe(16'h0123, 70, 1);
    wait_idle();
    for (int i = 0; i < 70; i++) expb[(35 + i) % 64] = 8'((1 + 3 * i) & 255);
    mism = 0;
    for (int o = 0; o < 64; o++) if (cap[o] !== expb[o]) mism++;
    chk("R10 page data with wrap", mism, 0);
    chk("R10 count saturates", cap_cnt, 64);
    chk("R10 start address", int'(cap_addr), 13'h0123);

    // R11 aborted frames
    cs_low(); send1(8'h06); xfer(8'hFF, 3, r); cs_high();
    rdsr(s);
    chk("R11 partial enable frame", int'(s), 8'h00);
    wren();
    base = launches;
    cs_low(); send1(8'h02); send1(8'h00); send1(8'h40); xfer(8'hC3, 4, r); cs_high();
    wait_idle();
    chk("R11 partial data byte no launch", launches - base, 0);
    rdsr(s);
    chk("R11 latch unchanged", int'(s), 8'h02);

    // R12 output enable
    chk("R12 so_en outside reads", bad_oe, 0);
    chk("R12 so_en idle", int'(so_en), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule